// File: doc/BRIEF.md
# Multicycle Integer Divider

This block divides a dividend of twice the operand width by a divisor and returns a quotient and a remainder, each as wide as the divisor. A two-bit size code picks an 8, 16 or 32-bit divisor, so the dividend is 16, 32 or 64 bits wide. A mode bit picks unsigned or two's-complement operation. One quotient bit is resolved per cycle by a restoring shift-subtract loop. The loop runs on magnitudes, and a final cycle applies the signs.

A caller raises `start_i` for one cycle while the unit is idle and then waits for the `done_o` pulse. When the divisor is zero, or the true quotient does not fit the destination range, the unit raises `div_err_o` in place of a result. In that case the previous quotient and remainder stay on the outputs. Sign handling follows two rules: the quotient is truncated toward zero, and a signed remainder takes the sign of the dividend.

Top module: `int_divider`

## Requirements
- R1: The size code selects the divisor width W: 0 gives 8, 1 gives 16, and 2 or 3 give 32. The dividend is taken from its low 2W bits. Quotient and remainder use their low W bits, and all bits above W read zero.
- R2: In unsigned mode (`signed_i`=0) the quotient is the floor of dividend/divisor, and the remainder is dividend minus quotient times divisor, always less than the divisor.
- R3: A zero divisor sets `div_err_o` with `done_o`. Quotient and remainder keep their previous values.
- R4: In unsigned mode, a quotient above 2^W-1 sets `div_err_o` and leaves quotient and remainder unchanged.
- R5: In signed mode (`signed_i`=1) the quotient is truncated toward zero. The remainder carries the dividend's sign and has a magnitude below the divisor's magnitude.
- R6: In signed mode, a quotient outside -2^(W-1) to 2^(W-1)-1 sets `div_err_o`. A quotient of exactly -2^(W-1) is valid, and +2^(W-1) is an error.
- R7: `start_i` has no effect while `busy_o` is high. The operation already running completes with its own operands.
- R8: `done_o` is high for exactly one cycle. Quotient, remainder and `div_err_o` hold until the next accepted start, which clears `div_err_o`.
- R9: `done_o` rises W+2 cycles after the clock edge that accepts `start_i`, whatever the operand values. `busy_o` is high from that edge until the cycle of `done_o`, and low during it.
- R10: After reset, `busy_o`, `done_o`, `div_err_o`, the quotient and the remainder are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a division; sampled only while idle |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| size_i | input | 2 | Divisor width code (0: 8, 1: 16, 2/3: 32) |
| dividend_i | input | 64 | Dividend, low 2W bits used |
| divisor_i | input | 32 | Divisor, low W bits used |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_err_o | output | 1 | Zero divisor or quotient out of range |
| quotient_o | output | 32 | Quotient, zero above bit W-1 |
| remainder_o | output | 32 | Remainder, zero above bit W-1 |

## Verification
A new request can arrive in the same cycle that the previous result completes. In that case the ignore rule and the completion pulse act on the same clock edge. The bench raises `start_i`, with different operands, both mid-loop and exactly on the edge where the sign fix-up writes the outputs. It then judges the busy and done timing, and the held result, against a behavioural model on every clock. Separately, error cases are placed right after valid results, so that a held quotient and a freshly raised `div_err_o` are observed together.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_LOOP = 2'd2,
    ST_FIX  = 2'd3
  } div_state_e;

  // size code -> divisor width in bits
  function automatic logic [6:0] size_width(input logic [1:0] code);
    case (code)
      2'd0:    size_width = 7'd8;
      2'd1:    size_width = 7'd16;
      default: size_width = 7'd32;
    endcase
  endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter  int unsigned MAX_W = 32,
  localparam int unsigned DD_W  = 2 * MAX_W,
  localparam int unsigned WID_W = $clog2(DD_W) + 1
) (
  input  logic             signed_i,
  input  logic [WID_W-1:0] width_i,
  input  logic [DD_W-1:0]  dividend_i,
  input  logic [MAX_W-1:0] divisor_i,
  output logic [MAX_W-1:0] hi_mag_o,
  output logic [MAX_W-1:0] lo_mag_o,
  output logic [MAX_W-1:0] dv_mag_o,
  output logic             dd_neg_o,
  output logic             dv_neg_o,
  output logic             dv_zero_o,
  output logic             mag_ovf_o
);

  int unsigned      w;
  logic [DD_W-1:0]  dmask, dd_m, dd_abs, dd_hi;
  logic [MAX_W-1:0] wmask, dv_m;

  always_comb begin
    w      = 32'(width_i);
    dmask  = {DD_W{1'b1}} >> (DD_W - 2 * w);
    wmask  = {MAX_W{1'b1}} >> (MAX_W - w);
    dd_m   = dividend_i & dmask;
    dv_m   = divisor_i & wmask;
    dd_neg_o = signed_i & dd_m[2*w-1];
    dv_neg_o = signed_i & dv_m[w-1];
    dd_abs = dd_neg_o ? ((~dd_m + 1'b1) & dmask) : dd_m;
    dd_hi  = dd_abs >> w;
    hi_mag_o = dd_hi[MAX_W-1:0];
    // left-align the low half so the loop always shifts out of the MSB
    lo_mag_o = (dd_abs[MAX_W-1:0] & wmask) << (MAX_W - w);
    dv_mag_o = dv_neg_o ? ((~dv_m + 1'b1) & wmask) : dv_m;
    dv_zero_o = (dv_m == '0);
    // quotient magnitude needs more than W bits
    mag_ovf_o = (hi_mag_o >= dv_mag_o);
  end

endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int unsigned MAX_W = 32
) (
  input  logic [MAX_W-1:0] rem_i,
  input  logic [MAX_W-1:0] lo_i,
  input  logic [MAX_W-1:0] dv_i,
  output logic [MAX_W-1:0] rem_o,
  output logic [MAX_W-1:0] lo_o
);

  logic [MAX_W:0] trial, diff;
  logic           fits;

  always_comb begin
    trial = {rem_i, lo_i[MAX_W-1]};
    diff  = trial - {1'b0, dv_i};
    fits  = (trial >= {1'b0, dv_i});
    rem_o = fits ? diff[MAX_W-1:0] : trial[MAX_W-1:0];
    lo_o  = {lo_i[MAX_W-2:0], fits};
  end

endmodule

// File: rtl/div_fix.sv
module div_fix #(
  parameter  int unsigned MAX_W = 32,
  localparam int unsigned DD_W  = 2 * MAX_W,
  localparam int unsigned WID_W = $clog2(DD_W) + 1,
  localparam int unsigned QW    = MAX_W + 1
) (
  input  logic             signed_i,
  input  logic [WID_W-1:0] width_i,
  input  logic [MAX_W-1:0] q_raw_i,
  input  logic [MAX_W-1:0] r_raw_i,
  input  logic             dd_neg_i,
  input  logic             dv_neg_i,
  input  logic             dv_zero_i,
  input  logic             mag_ovf_i,
  output logic [MAX_W-1:0] quo_o,
  output logic [MAX_W-1:0] rem_o,
  output logic             err_o
);

  int unsigned      w;
  logic [MAX_W-1:0] wmask, q_mag;
  logic [QW-1:0]    half;
  logic             q_neg, sig_ovf;

  always_comb begin
    w     = 32'(width_i);
    wmask = {MAX_W{1'b1}} >> (MAX_W - w);
    q_mag = q_raw_i & wmask;
    q_neg = dd_neg_i ^ dv_neg_i;
    half  = QW'(1) << (w - 1);
    // negative side may reach exactly 2^(W-1), positive side may not
    sig_ovf = signed_i & (q_neg ? ({1'b0, q_mag} > half) : ({1'b0, q_mag} >= half));
    err_o = dv_zero_i | mag_ovf_i | sig_ovf;
    quo_o = (q_neg ? (~q_mag + 1'b1) : q_mag) & wmask;
    rem_o = (dd_neg_i ? (~r_raw_i + 1'b1) : r_raw_i) & wmask;
  end

endmodule

// File: rtl/int_divider.sv
module int_divider
  import div_pkg::*;
#(
  parameter  int unsigned MAX_W = 32,
  localparam int unsigned DD_W  = 2 * MAX_W,
  localparam int unsigned WID_W = $clog2(DD_W) + 1,
  localparam int unsigned LAT_W = WID_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic [1:0]       size_i,
  input  logic [DD_W-1:0]  dividend_i,
  input  logic [MAX_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             div_err_o,
  output logic [MAX_W-1:0] quotient_o,
  output logic [MAX_W-1:0] remainder_o
);

  div_state_e       st_q;
  logic [WID_W-1:0] cnt_q, wid_q, wid_in;
  logic             sgn_q;
  logic [DD_W-1:0]  dd_q;
  logic [MAX_W-1:0] dv_in_q, rem_q, lo_q, dv_q;
  logic             dd_neg_q, dv_neg_q, zero_q, ovf_q;
  logic [MAX_W-1:0] quo_q, remd_q;
  logic             err_q, done_q;

  logic [MAX_W-1:0] p_hi, p_lo, p_dv, s_rem, s_lo, f_quo, f_rem;
  logic             p_dd_neg, p_dv_neg, p_zero, p_ovf, f_err;

  assign wid_in = WID_W'(size_width(size_i));

  div_prep #(.MAX_W(MAX_W)) u_prep (
    .signed_i  (sgn_q),
    .width_i   (wid_q),
    .dividend_i(dd_q),
    .divisor_i (dv_in_q),
    .hi_mag_o  (p_hi),
    .lo_mag_o  (p_lo),
    .dv_mag_o  (p_dv),
    .dd_neg_o  (p_dd_neg),
    .dv_neg_o  (p_dv_neg),
    .dv_zero_o (p_zero),
    .mag_ovf_o (p_ovf)
  );

  div_step #(.MAX_W(MAX_W)) u_step (
    .rem_i(rem_q),
    .lo_i (lo_q),
    .dv_i (dv_q),
    .rem_o(s_rem),
    .lo_o (s_lo)
  );

  div_fix #(.MAX_W(MAX_W)) u_fix (
    .signed_i (sgn_q),
    .width_i  (wid_q),
    .q_raw_i  (lo_q),
    .r_raw_i  (rem_q),
    .dd_neg_i (dd_neg_q),
    .dv_neg_i (dv_neg_q),
    .dv_zero_i(zero_q),
    .mag_ovf_i(ovf_q),
    .quo_o    (f_quo),
    .rem_o    (f_rem),
    .err_o    (f_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      wid_q    <= WID_W'(8);
      sgn_q    <= 1'b0;
      dd_q     <= '0;
      dv_in_q  <= '0;
      rem_q    <= '0;
      lo_q     <= '0;
      dv_q     <= '0;
      dd_neg_q <= 1'b0;
      dv_neg_q <= 1'b0;
      zero_q   <= 1'b0;
      ovf_q    <= 1'b0;
      quo_q    <= '0;
      remd_q   <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          sgn_q   <= signed_i;
          wid_q   <= wid_in;
          dd_q    <= dividend_i;
          dv_in_q <= divisor_i;
          err_q   <= 1'b0;
          st_q    <= ST_PREP;
        end
        ST_PREP: begin
          rem_q    <= p_hi;
          lo_q     <= p_lo;
          dv_q     <= p_dv;
          dd_neg_q <= p_dd_neg;
          dv_neg_q <= p_dv_neg;
          zero_q   <= p_zero;
          ovf_q    <= p_ovf;
          cnt_q    <= wid_q;
          st_q     <= ST_LOOP;
        end
        ST_LOOP: begin
          rem_q <= s_rem;
          lo_q  <= s_lo;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == WID_W'(1)) st_q <= ST_FIX;
        end
        ST_FIX: begin
          err_q <= f_err;
          if (!f_err) begin
            quo_q  <= f_quo;
            remd_q <= f_rem;
          end
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign div_err_o   = err_q;
  assign quotient_o  = quo_q;
  assign remainder_o = remd_q;

  // ---------------- assertions ----------------
  logic [LAT_W-1:0] lat_q;
  logic [MAX_W-1:0] chk_mask, chk_rabs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        lat_q <= '0;
    else if (st_q == ST_IDLE && start_i) lat_q <= '0;
    else if (busy_o)                     lat_q <= lat_q + 1'b1;
  end

  always_comb begin
    chk_mask = {MAX_W{1'b1}} >> (MAX_W - 32'(wid_q));
    chk_rabs = dd_neg_q ? ((~remainder_o + 1'b1) & chk_mask) : remainder_o;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_err_o))); // R8
  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_err_o) |-> ($stable(quotient_o) && $stable(remainder_o))); // R3
  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LAT_W'(wid_q) + LAT_W'(2))); // R9
  AST_IDLE_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
  AST_BUSY_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (st_q != ST_PREP)); // R7
  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_err_o) |-> (chk_rabs < dv_q)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !div_err_o && sgn_q && quotient_o != '0)
      |-> (quotient_o[wid_q-1] == (dd_neg_q ^ dv_neg_q))); // R6

endmodule

// File: tb/int_divider_tb_top.sv
`timescale 1ns/1ps
module int_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sgn = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [63:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, err;
  logic [31:0] quo, rem;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  int_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .signed_i(sgn), .size_i(size),
    .dividend_i(dividend), .divisor_i(divisor), .busy_o(busy), .done_o(done),
    .div_err_o(err), .quotient_o(quo), .remainder_o(rem)
  );

  // ---------------- reference model ----------------
  bit          m_busy = 0, m_done = 0, m_err = 0, m_ign = 0;
  int          m_cnt = 0;
  logic [31:0] m_q = '0, m_r = '0;
  bit          a_sg;
  logic [1:0]  a_sz;
  logic [63:0] a_dd;
  logic [31:0] a_dv;
  string       m_tag = "R10";

  function automatic int width_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
  endfunction

  task automatic model_eval();
    int w;
    logic [63:0] dmask;
    logic [31:0] wmask;
    logic signed [129:0] a, b, q, r, lim_hi, lim_lo;
    w = width_of(a_sz);
    dmask = (w == 32) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (2 * w)) - 64'd1);
    wmask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    a = $signed({66'd0, a_dd & dmask});
    b = $signed({98'd0, a_dv & wmask});
    if (a_sg && a_dd[2*w-1]) a = a - (130'sd1 <<< (2 * w));
    if (a_sg && a_dv[w-1])   b = b - (130'sd1 <<< w);
    if (b == 0) begin
      m_err = 1; m_tag = "R3";
    end else begin
      q = a / b;  // truncates toward zero, R5
      r = a % b;  // sign of dividend, R5
      if (a_sg) begin
        lim_hi = (130'sd1 <<< (w - 1)) - 130'sd1;
        lim_lo = -(130'sd1 <<< (w - 1));
      end else begin
        lim_hi = (130'sd1 <<< w) - 130'sd1;
        lim_lo = 130'sd0;
      end
      if (q > lim_hi || q < lim_lo) begin
        m_err = 1; m_tag = a_sg ? "R6" : "R4";
      end else begin
        m_err = 0; m_tag = a_sg ? "R5" : "R2";
        m_q = q[31:0] & wmask;
        m_r = r[31:0] & wmask;
      end
    end
    if (a_sz == 2'd3) m_tag = {m_tag, "/R1"};
    if (m_ign) m_tag = {m_tag, "/R7"};
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_cnt = 0; m_q = '0; m_r = '0; m_ign = 0;
    end else if (!m_busy && start) begin
      m_busy = 1; m_done = 0; m_err = 0; m_ign = 0;
      m_cnt = width_of(size) + 2;  // R9
      a_sg = sgn; a_sz = size; a_dd = dividend; a_dv = divisor;
    end else if (m_busy) begin
      if (start) m_ign = 1;  // R7: ignored while busy
      m_done = 0;
      m_cnt--;
      if (m_cnt == 0) begin
        m_busy = 0; m_done = 1;
        model_eval();
      end
    end else begin
      m_done = 0;
    end
  end

  // ---------------- per-clock compare ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      bit bad;
      bad = 0;
      n_vec++;
      if (busy !== m_busy) begin
        $display("FAIL R9 busy actual=%0b expected=%0b t=%0t", busy, m_busy, $time); bad = 1;
      end
      if (done !== m_done) begin
        $display("FAIL R8 done actual=%0b expected=%0b t=%0t", done, m_done, $time); bad = 1;
      end
      if (err !== m_err) begin
        $display("FAIL %s err actual=%0b expected=%0b t=%0t", m_tag, err, m_err, $time); bad = 1;
      end
      if (quo !== m_q) begin
        $display("FAIL %s quotient actual=%h expected=%h t=%0t", m_tag, quo, m_q, $time); bad = 1;
      end
      if (rem !== m_r) begin
        $display("FAIL %s remainder actual=%h expected=%h t=%0t", m_tag, rem, m_r, $time); bad = 1;
      end
      if (bad) n_bad++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_op(input bit sg, input logic [1:0] sz, input logic [63:0] dd,
                        input logic [31:0] dv, input int poke_at);
    @(negedge clk);
    start = 1; sgn = sg; size = sz; dividend = dd; divisor = dv;
    @(negedge clk);
    start = 0;
    if (poke_at > 0) begin
      repeat (poke_at - 1) @(negedge clk);
      start = 1; sgn = ~sg; size = ~sz; dividend = ~dd; divisor = dv + 32'd1;
      @(negedge clk);
      start = 0;
    end
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    n_vec++;
    if (busy !== 1'b0 || done !== 1'b0 || err !== 1'b0 || quo !== '0 || rem !== '0) begin
      n_bad++;
      $display("FAIL R10 reset actual=%b%b%b %h %h expected=000 0 0", busy, done, err, quo, rem);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 unsigned basics
    run_op(0, 2'd0, 64'd100, 32'd7, 0);
    run_op(0, 2'd0, 64'h05FF, 32'd6, 0);            // quotient 255, R4 boundary ok
    run_op(0, 2'd1, 64'h1234_5678, 32'h1234, 0);
    run_op(0, 2'd2, 64'h0123_4567_89AB_CDEF, 32'hFEDC_BA98, 0);
    // R4 unsigned overflow right after a valid result
    run_op(0, 2'd0, 64'h0600, 32'd6, 0);
    run_op(0, 2'd2, 64'h1_0000_0000, 32'd1, 0);
    // R3 zero divisor on every size
    run_op(0, 2'd0, 64'd55, 32'h0000_0100, 0);      // low 8 bits zero
    run_op(1, 2'd1, 64'd55, 32'h0, 0);
    run_op(0, 2'd2, 64'd55, 32'h0, 0);
    // R5 signed truncation and remainder sign
    run_op(1, 2'd0, 64'hFFF9, 32'h02, 0);           // -7/2 -> -3 r -1
    run_op(1, 2'd0, 64'h0007, 32'hFE, 0);           // 7/-2 -> -3 r 1
    run_op(1, 2'd0, 64'hFFF9, 32'hFE, 0);           // -7/-2 -> 3 r -1
    run_op(1, 2'd1, 64'hFFFF_8000, 32'h0007, 0);
    // R6 signed range edges
    run_op(1, 2'd0, 64'hFF00, 32'h02, 0);           // -128 valid
    run_op(1, 2'd0, 64'h0100, 32'hFE, 0);           // -128 valid
    run_op(1, 2'd0, 64'h0100, 32'h02, 0);           // +128 error
    run_op(1, 2'd0, 64'h8000, 32'hFF, 0);           // error
    run_op(1, 2'd2, 64'hFFFF_FFFF_8000_0000, 32'h1, 0);
    run_op(1, 2'd2, 64'h8000_0000_0000_0000, 32'hFFFF_FFFF, 0);
    // R1 size code 3 and ignored high bits
    run_op(0, 2'd3, 64'hDEAD_BEEF_0000_1234, 32'hFFFF_FFF0, 0);
    run_op(0, 2'd0, 64'hDEAD_BEEF_1234_0064, 32'hABCD_EF07, 0);
    run_op(1, 2'd1, 64'hAAAA_AAAA_FFFF_FF9C, 32'h5555_0007, 0);
    // R7 start while busy: mid-loop and on the completion edge
    run_op(0, 2'd0, 64'd200, 32'd9, 3);
    run_op(1, 2'd0, 64'hFFF0, 32'h03, 10);
    run_op(0, 2'd1, 64'd99999, 32'd77, 18);
    run_op(1, 2'd2, 64'hFFFF_FFFF_FFFF_0000, 32'd13, 34);

    // random mix
    for (int i = 0; i < 300; i++) begin
      bit          sg;
      logic [1:0]  sz;
      logic [63:0] dd;
      logic [31:0] dv;
      sg = 1'($urandom);
      sz = 2'($urandom);
      dv = $urandom;
      if ($urandom_range(15, 0) == 0) dv = '0;
      if ($urandom_range(2, 0) == 0) dd = {$urandom, $urandom};
      else begin
        dd = {32'd0, $urandom} >> $urandom_range(24, 0);
        if (sg && $urandom_range(1, 0) == 1) dd = -dd;
      end
      run_op(sg, sz, dd, dv, ($urandom_range(7, 0) == 0) ? 4 : 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule